// File: doc/BRIEF.md
# Coprocessor Control Register File

This block holds the control and status registers of a signal-processing coprocessor and makes them available to a host bus. The host reaches each register at a 32-bit-aligned offset inside a small address window. An access can be a byte, a 16-bit word or a 32-bit long. Partial writes are merged into the full register in big-endian lane order. The current value of every writable register is also driven on a dedicated output, so the coprocessor core can use it.

Several registers do more than store data:

- The offset at 0x1C reads the divider remainder but writes the divide-control register.
- The matrix pointer is forced into a fixed address window.
- Reading the status flags hides the latch-clear bits.
- The control register protects its version field and its six interrupt latches.
- Two command bits in the control register act once and are never stored.
- A read-only offset returns the top byte of the accumulator, sign-extended.

Every access inside the window is answered one cycle after the request. A read also raises a data-valid strobe.

Top module: `cop_ctrl_regs`

## Requirements
- R1: Synchronous active-low reset sets the program counter to 0x00F1B000, modulo and data organisation to 0xFFFFFFFF, control to 0x00002000 and all other registers to 0, with `ack_o`, `rvalid_o` and `host_irq_o` low.
- R2: A request whose byte address is below WIN_BYTES (64) gets `ack_o` high in the next cycle. A request at or above it gets no acknowledge and changes no register.
- R3: Partial writes are merged big-endian and leave the other bits unchanged. `size_i` 0 is a byte and takes its data from `wdata_i[7:0]`; address bits 1:0 = 0 select bits 31:24 and 3 selects bits 7:0. `size_i` 1 is a word and takes its data from `wdata_i[15:0]`; address bit 1 = 0 selects bits 31:16. `size_i` 2 or 3 is a long.
- R4: A read raises `rvalid_o` with `ack_o`. A byte read returns the addressed lane in `rdata_o[7:0]`, and a word read returns it in `rdata_o[15:0]`, with the upper bits zero. Address bit 0 is ignored for words, and bits 1:0 are ignored for longs.
- R5: Offset 0x1C reads `remainder_i`, while a write of any size there updates the divide-control register.
- R6: A write to offset 0x08 stores 0x00F1B000 ORed with bits 11:2 of the merged value.
- R7: Reading the flags register (offset 0x00) returns bits 13:9 as zero. The stored value, visible on `flags_o`, keeps them.
- R8: A write to the control register (offset 0x14) cannot change the version field (bits 15:12) or the latch bits (6..10 and 16).
- R9: Writing control bit 1 as 1 gives a one-cycle `host_irq_o` pulse together with the acknowledge. The bit always reads 0.
- R10: Writing control bit 2 as 1 sets latch 0 (control bit 6). The bit always reads 0. A pulse on `irq_set_i[k]` sets latch k: bits 6..10 for k=0..4 and bit 16 for k=5.
- R11: A flags write whose merged value has bit 9+k set (k=0..4) clears latch k, and bit 17 clears latch 5. A set arriving in the same cycle wins over a clear.
- R12: Offset 0x20 reads `acc_hi_i` sign-extended to 32 bits, and writes there are ignored.
- R13: Reads of offsets 0x24 up to WIN_BYTES-1 return 0xFFFFFFFF, and writes there are acknowledged but ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 word, 2/3 long |
| addr_i | input | 8 | Byte address inside the block's decode range |
| wdata_i | input | 32 | Write data, right-aligned for byte and word |
| remainder_i | input | 32 | Divider remainder shown at offset 0x1C |
| acc_hi_i | input | 8 | Accumulator bits 39:32 |
| irq_set_i | input | 6 | Interrupt line pulses that set the latches |
| ack_o | output | 1 | Access acknowledge |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| host_irq_o | output | 1 | One-cycle interrupt pulse towards the host |
| flags_o | output | 32 | Stored flags register |
| mtx_ctrl_o | output | 32 | Matrix control |
| mtx_ptr_o | output | 32 | Matrix pointer |
| data_org_o | output | 32 | Data organisation |
| pc_o | output | 32 | Program counter |
| ctrl_o | output | 32 | Control register |
| modulo_o | output | 32 | Modulo register |
| div_ctrl_o | output | 32 | Divide control |

## Verification
The bench builds the block with its default parameters: ADDR_W = 8 and WIN_BYTES = 64. These values reach three address regions with a single 8-bit bus:

- the mapped offsets 0x00–0x23;
- the unmapped hole 0x24–0x3F, which must read all ones;
- the region 0x40–0xFF above the window, where no acknowledge may appear.

The matrix-pointer window is held at bits 11:2, so writing all ones shows exactly which bits survive.

// File: rtl/cop_ctrl_pkg.sv
// Package: shared encodings and field masks for the coprocessor control
// register file. Assumes 32-bit registers on 4-byte offsets.
package cop_ctrl_pkg;

    localparam int NREG = 9;

    typedef enum logic [3:0] {
        RI_FLAGS = 4'd0,
        RI_MCTL  = 4'd1,
        RI_MPTR  = 4'd2,
        RI_DORG  = 4'd3,
        RI_PC    = 4'd4,
        RI_CTRL  = 4'd5,
        RI_MOD   = 4'd6,
        RI_DIV   = 4'd7,
        RI_ACC   = 4'd8
    } reg_idx_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    localparam logic [31:0] CTRL_CMD_MASK = 32'h0000_0006;
    localparam logic [31:0] CTRL_VER_MASK = 32'h0000_F000;
    localparam logic [31:0] CTRL_LAT_MASK = 32'h0001_07C0;
    localparam logic [31:0] FLAG_HIDE_MASK = 32'h0000_3E00;

    // Bit position of interrupt latch k inside the control register.
    function automatic int unsigned lat_pos(input int unsigned k);
        return (k < 5) ? (6 + k) : 16;
    endfunction

    // Bit position of the flags bit that clears latch k.
    function automatic int unsigned clr_pos(input int unsigned k);
        return (k < 5) ? (9 + k) : 17;
    endfunction

endpackage

// File: rtl/cop_ctrl_decode.sv
// Address decoder: flags whether an address lies in the window and produces
// a one-hot register select. Assumes registers at consecutive 4-byte offsets.
module cop_ctrl_decode #(
    parameter int ADDR_W    = 8,
    parameter int WIN_BYTES = 64,
    parameter int NREG      = 9
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_win_o,
    output logic [NREG-1:0]   hit_o
);
    localparam int IDXW = ADDR_W - 2;
    localparam logic [ADDR_W:0] WIN_LIM = (ADDR_W+1)'(WIN_BYTES);

    // Window test against the byte limit.
    always_comb in_win_o = ({1'b0, addr_i} < WIN_LIM);

    // One select line per mapped register.
    for (genvar g = 0; g < NREG; g++) begin : g_hit
        always_comb hit_o[g] = in_win_o && (addr_i[ADDR_W-1:2] == IDXW'(g));
    end
endmodule

// File: rtl/cop_ctrl_lane_merge.sv
// Write merge: folds byte or word write data into a 32-bit register value
// using big-endian lane order. Byte data comes in bits 7:0, word data in 15:0.
module cop_ctrl_lane_merge
    import cop_ctrl_pkg::*;
(
    input  logic [31:0] old_i,
    input  logic [31:0] wdata_i,
    input  logic [1:0]  size_i,
    input  logic [1:0]  lane_i,
    output logic [31:0] merged_o
);
    logic [4:0]  bshift;
    logic [31:0] bmask;

    // Byte lane 0 maps to bits 31:24, so shift = (3 - lane) * 8.
    always_comb begin
        bshift = {~lane_i, 3'b000};
        bmask  = 32'h0000_00FF << bshift;
    end

    // Merge by access size.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: merged_o = (old_i & ~bmask) | ({24'd0, wdata_i[7:0]} << bshift);
            SZ_WORD: merged_o = lane_i[1] ? {old_i[31:16], wdata_i[15:0]}
                                          : {wdata_i[15:0], old_i[15:0]};
            default: merged_o = wdata_i;
        endcase
    end
endmodule

// File: rtl/cop_ctrl_read_lane.sv
// Read lane extractor: returns the addressed byte or word of a 32-bit value,
// right-aligned and zero-extended, in big-endian lane order.
module cop_ctrl_read_lane
    import cop_ctrl_pkg::*;
(
    input  logic [31:0] full_i,
    input  logic [1:0]  size_i,
    input  logic [1:0]  lane_i,
    output logic [31:0] data_o
);
    logic [31:0] shifted;

    // Bring the addressed byte down to bits 7:0.
    always_comb shifted = full_i >> {~lane_i, 3'b000};

    // Select by access size.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: data_o = {24'd0, shifted[7:0]};
            SZ_WORD: data_o = lane_i[1] ? {16'd0, full_i[15:0]} : {16'd0, full_i[31:16]};
            default: data_o = full_i;
        endcase
    end
endmodule

// File: rtl/cop_ctrl_regs.sv
// Coprocessor control register file (top). Decodes host accesses, merges
// partial writes big-endian, applies per-register write rules and answers
// every in-window access one cycle later. Assumes one access per request
// cycle. Uses a synchronous active-low reset.
module cop_ctrl_regs
    import cop_ctrl_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          WIN_BYTES = 64,
    parameter logic [31:0] PTR_BASE  = 32'h00F1_B000,
    parameter int          PTR_LSB   = 2,
    parameter int          PTR_MSB   = 11,
    parameter logic [31:0] PC_RST    = 32'h00F1_B000,
    parameter logic [31:0] CTRL_RST  = 32'h0000_2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [31:0]       remainder_i,
    input  logic [7:0]        acc_hi_i,
    input  logic [5:0]        irq_set_i,
    output logic              ack_o,
    output logic              rvalid_o,
    output logic [31:0]       rdata_o,
    output logic              host_irq_o,
    output logic [31:0]       flags_o,
    output logic [31:0]       mtx_ctrl_o,
    output logic [31:0]       mtx_ptr_o,
    output logic [31:0]       data_org_o,
    output logic [31:0]       pc_o,
    output logic [31:0]       ctrl_o,
    output logic [31:0]       modulo_o,
    output logic [31:0]       div_ctrl_o
);
    localparam logic [31:0] PTR_KEEP =
        ((32'h1 << (PTR_MSB + 1)) - 32'h1) & ~((32'h1 << PTR_LSB) - 32'h1);
    localparam logic [31:0] CTRL_KEEP = CTRL_VER_MASK | CTRL_LAT_MASK;

    logic            in_win;
    logic [NREG-1:0] hit;
    logic [31:0]     cur    [NREG];
    logic [31:0]     rd_val [NREG];
    logic [31:0]     old_sel, merged, rd_full, rd_lane;
    logic [NREG-1:0] wr;
    logic            rd_en;
    logic [31:0]     lat_set, lat_clr, ctrl_base, ctrl_nxt;

    logic [31:0] flags_q, mctl_q, mptr_q, dorg_q, pc_q, ctrl_q, mod_q, div_q;
    logic        ack_q, rvalid_q, hirq_q;
    logic [31:0] rdata_q;

    cop_ctrl_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .NREG(NREG)) u_dec (
        .addr_i  (addr_i),
        .in_win_o(in_win),
        .hit_o   (hit)
    );

    // Stored values, used as merge base for writes.
    always_comb begin
        cur[RI_FLAGS] = flags_q;
        cur[RI_MCTL]  = mctl_q;
        cur[RI_MPTR]  = mptr_q;
        cur[RI_DORG]  = dorg_q;
        cur[RI_PC]    = pc_q;
        cur[RI_CTRL]  = ctrl_q;
        cur[RI_MOD]   = mod_q;
        cur[RI_DIV]   = div_q;
        cur[RI_ACC]   = 32'd0;
    end

    // Values seen by the host on reads.
    always_comb begin
        rd_val[RI_FLAGS] = flags_q & ~FLAG_HIDE_MASK;
        rd_val[RI_MCTL]  = mctl_q;
        rd_val[RI_MPTR]  = mptr_q;
        rd_val[RI_DORG]  = dorg_q;
        rd_val[RI_PC]    = pc_q;
        rd_val[RI_CTRL]  = ctrl_q;
        rd_val[RI_MOD]   = mod_q;
        rd_val[RI_DIV]   = remainder_i;
        rd_val[RI_ACC]   = {{24{acc_hi_i[7]}}, acc_hi_i};
    end

    // One-hot selection of write base and read value.
    always_comb begin
        old_sel = 32'd0;
        rd_full = (|hit) ? 32'd0 : 32'hFFFF_FFFF;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                old_sel = old_sel | cur[i];
                rd_full = rd_full | rd_val[i];
            end
        end
    end

    cop_ctrl_lane_merge u_merge (
        .old_i   (old_sel),
        .wdata_i (wdata_i),
        .size_i  (size_i),
        .lane_i  (addr_i[1:0]),
        .merged_o(merged)
    );

    cop_ctrl_read_lane u_rlane (
        .full_i(rd_full),
        .size_i(size_i),
        .lane_i(addr_i[1:0]),
        .data_o(rd_lane)
    );

    // Per-register write strobes; the accumulator slot is read-only.
    always_comb begin
        wr = {NREG{req_i & we_i}} & hit;
        wr[RI_ACC] = 1'b0;
        rd_en = req_i & ~we_i & in_win;
    end

    // Latch set and clear vectors for the control register.
    always_comb begin
        lat_set = 32'd0;
        lat_clr = 32'd0;
        for (int unsigned k = 0; k < 6; k++) begin
            lat_set[lat_pos(k)] = irq_set_i[k];
            lat_clr[lat_pos(k)] = wr[RI_FLAGS] & merged[clr_pos(k)];
        end
        lat_set[lat_pos(0)] = lat_set[lat_pos(0)] | (wr[RI_CTRL] & merged[2]);
    end

    // Next control value: protected fields kept, commands dropped, set over clear.
    always_comb begin
        ctrl_base = wr[RI_CTRL]
                  ? ((merged & ~(CTRL_KEEP | CTRL_CMD_MASK)) | (ctrl_q & CTRL_KEEP))
                  : ctrl_q;
        ctrl_nxt  = (ctrl_base & ~lat_clr) | lat_set;
    end

    // Plain data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= 32'd0;
            mctl_q  <= 32'd0;
            dorg_q  <= 32'hFFFF_FFFF;
            pc_q    <= PC_RST;
            mod_q   <= 32'hFFFF_FFFF;
            div_q   <= 32'd0;
        end else begin
            if (wr[RI_FLAGS]) flags_q <= merged;
            if (wr[RI_MCTL])  mctl_q  <= merged;
            if (wr[RI_DORG])  dorg_q  <= merged;
            if (wr[RI_PC])    pc_q    <= merged;
            if (wr[RI_MOD])   mod_q   <= merged;
            if (wr[RI_DIV])   div_q   <= merged;
        end
    end

    // Matrix pointer, confined to its window.
    always_ff @(posedge clk) begin
        if (!rst_n)           mptr_q <= 32'd0;
        else if (wr[RI_MPTR]) mptr_q <= PTR_BASE | (merged & PTR_KEEP);
    end

    // Control register with latches.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_nxt;
    end

    // Host response and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q    <= 1'b0;
            rvalid_q <= 1'b0;
            rdata_q  <= 32'd0;
            hirq_q   <= 1'b0;
        end else begin
            ack_q    <= req_i & in_win;
            rvalid_q <= rd_en;
            if (rd_en) rdata_q <= rd_lane;
            hirq_q   <= wr[RI_CTRL] & merged[1];
        end
    end

    assign ack_o      = ack_q;
    assign rvalid_o   = rvalid_q;
    assign rdata_o    = rdata_q;
    assign host_irq_o = hirq_q;
    assign flags_o    = flags_q;
    assign mtx_ctrl_o = mctl_q;
    assign mtx_ptr_o  = mptr_q;
    assign data_org_o = dorg_q;
    assign pc_o       = pc_q;
    assign ctrl_o     = ctrl_q;
    assign modulo_o   = mod_q;
    assign div_ctrl_o = div_q;
endmodule

// File: rtl/cop_ctrl_regs_chk.sv
// Checker for cop_ctrl_regs: temporal properties on its ports, bound below.
module cop_ctrl_regs_chk #(
    parameter int          ADDR_W    = 8,
    parameter int          WIN_BYTES = 64,
    parameter logic [31:0] PTR_BASE  = 32'h00F1_B000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              we_i,
    input logic [1:0]        size_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ack_o,
    input logic              rvalid_o,
    input logic [31:0]       rdata_o,
    input logic              host_irq_o,
    input logic [31:0]       mtx_ptr_o,
    input logic [31:0]       pc_o,
    input logic [31:0]       ctrl_o
);
    localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(WIN_BYTES);
    localparam logic [ADDR_W-3:0] CTRL_IDX = (ADDR_W-2)'(5);

    p_ack_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ({1'b0, addr_i} < LIM)) |=> ack_o);

    p_ack_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !({1'b0, addr_i} < LIM)) |=> !ack_o);

    p_rvalid_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> ack_o);

    p_ptr_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mtx_ptr_o == 32'd0) || ((mtx_ptr_o & ~32'h0000_0FFC) == PTR_BASE));

    p_flags_hide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && addr_i < ADDR_W'(4) && size_i[1]) |=> (rdata_o[13:9] == 5'd0));

    p_version_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(ctrl_o[15:12]));

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_o |-> $past(req_i && we_i && addr_i[ADDR_W-1:2] == CTRL_IDX));

    p_cmd_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && addr_i[ADDR_W-1:2] == CTRL_IDX) |=> (ctrl_o[2:1] == 2'b00));

    p_pc_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && we_i) |=> $stable(pc_o));
endmodule

bind cop_ctrl_regs cop_ctrl_regs_chk #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .PTR_BASE(PTR_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .size_i(size_i),
    .addr_i(addr_i), .ack_o(ack_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .host_irq_o(host_irq_o), .mtx_ptr_o(mtx_ptr_o), .pc_o(pc_o), .ctrl_o(ctrl_o)
);

// File: tb/cop_ctrl_regs_bench.sv
// Scoreboard bench: driver tasks queue the expected response of every
// acknowledged access; a monitor pops and compares on each acknowledge.
module cop_ctrl_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, we_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic [7:0]  addr_i = 8'd0;
    logic [31:0] wdata_i = 32'd0, remainder_i = 32'd0;
    logic [7:0]  acc_hi_i = 8'd0;
    logic [5:0]  irq_set_i = 6'd0;
    logic        ack_o, rvalid_o, host_irq_o;
    logic [31:0] rdata_o, flags_o, mtx_ctrl_o, mtx_ptr_o, data_org_o;
    logic [31:0] pc_o, ctrl_o, modulo_o, div_ctrl_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] exp_q [$];
    bit          exp_rd_q [$];
    string       exp_tag_q [$];

    cop_ctrl_regs u_cop_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .size_i(size_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .remainder_i(remainder_i),
        .acc_hi_i(acc_hi_i), .irq_set_i(irq_set_i), .ack_o(ack_o),
        .rvalid_o(rvalid_o), .rdata_o(rdata_o), .host_irq_o(host_irq_o),
        .flags_o(flags_o), .mtx_ctrl_o(mtx_ctrl_o), .mtx_ptr_o(mtx_ptr_o),
        .data_org_o(data_org_o), .pc_o(pc_o), .ctrl_o(ctrl_o),
        .modulo_o(modulo_o), .div_ctrl_o(div_ctrl_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Monitor: compare each acknowledge with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && ack_o) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected ack", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                bit          r;
                string       t;
                e = exp_q.pop_front();
                r = exp_rd_q.pop_front();
                t = exp_tag_q.pop_front();
                chk({t, " rvalid"}, {31'd0, rvalid_o}, {31'd0, r});
                if (r) chk(t, rdata_o, e);
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver: one access, expectation queued when an acknowledge is due.
    task automatic acc(input bit w, input logic [7:0] a, input logic [1:0] s,
                       input logic [31:0] d, input logic [31:0] e, input string tag);
        @(negedge clk);
        if (a < 8'h40) begin
            exp_q.push_back(e);
            exp_rd_q.push_back(!w);
            exp_tag_q.push_back(tag);
        end
        req_i = 1'b1; we_i = w; addr_i = a; size_i = s; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        if (a >= 8'h40) chk({tag, " no ack"}, {31'd0, ack_o}, 32'd0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d,
                      input string tag);
        acc(1'b1, a, s, d, 32'd0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s, input logic [31:0] e,
                      input string tag);
        acc(1'b0, a, s, 32'd0, e, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc_o, 32'h00F1_B000);
        chk("R1 modulo", modulo_o, 32'hFFFF_FFFF);
        chk("R1 data_org", data_org_o, 32'hFFFF_FFFF);
        chk("R1 ctrl", ctrl_o, 32'h0000_2000);
        chk("R1 flags", flags_o, 32'd0);
        chk("R1 div", div_ctrl_o, 32'd0);
        chk("R1 mptr", mtx_ptr_o, 32'd0);
        chk("R1 ack/irq", {30'd0, ack_o, host_irq_o}, 32'd0);
        rst_n = 1'b1;
        rd(8'h14, 2'd2, 32'h0000_2000, "R1 ctrl read");

        // R3 merging into the program counter
        wr(8'h10, 2'd2, 32'h1234_5678, "R3 long");
        rd(8'h10, 2'd2, 32'h1234_5678, "R3 long read");
        wr(8'h10, 2'd0, 32'h0000_00AB, "R3 byte0");
        chk("R3 byte0 lane", pc_o, 32'hAB34_5678);
        wr(8'h13, 2'd0, 32'h0000_00CD, "R3 byte3");
        chk("R3 byte3 lane", pc_o, 32'hAB34_56CD);
        wr(8'h12, 2'd1, 32'h0000_BEEF, "R3 word2");
        chk("R3 word low", pc_o, 32'hAB34_BEEF);
        wr(8'h10, 2'd1, 32'h0000_1111, "R3 word0");
        chk("R3 word high", pc_o, 32'h1111_BEEF);

        // R4 partial reads
        rd(8'h11, 2'd0, 32'h0000_0011, "R4 byte1");
        rd(8'h12, 2'd0, 32'h0000_00BE, "R4 byte2");
        rd(8'h10, 2'd1, 32'h0000_1111, "R4 word0");
        rd(8'h13, 2'd1, 32'h0000_BEEF, "R4 word odd addr");
        rd(8'h12, 2'd3, 32'h1111_BEEF, "R4 long unaligned");

        // Other plain registers
        wr(8'h04, 2'd2, 32'hDEAD_BEEF, "R3 mctl");
        rd(8'h04, 2'd2, 32'hDEAD_BEEF, "R3 mctl read");
        wr(8'h0C, 2'd0, 32'h0000_0000, "R3 dorg byte");
        chk("R3 dorg", data_org_o, 32'h00FF_FFFF);
        wr(8'h1A, 2'd1, 32'h0000_1234, "R3 mod word");
        chk("R3 mod", modulo_o, 32'hFFFF_1234);

        // R5 remainder / divide control split
        remainder_i = 32'hCAFE_F00D;
        rd(8'h1C, 2'd2, 32'hCAFE_F00D, "R5 rem read");
        wr(8'h1C, 2'd2, 32'h0000_0011, "R5 div write");
        chk("R5 div", div_ctrl_o, 32'h0000_0011);
        rd(8'h1C, 2'd2, 32'hCAFE_F00D, "R5 rem after write");
        wr(8'h1C, 2'd0, 32'h0000_0080, "R5 div byte");
        chk("R5 div byte", div_ctrl_o, 32'h8000_0011);

        // R6 matrix pointer window
        wr(8'h08, 2'd2, 32'hFFFF_FFFF, "R6 ptr ones");
        chk("R6 ptr ones", mtx_ptr_o, 32'h00F1_BFFC);
        rd(8'h08, 2'd2, 32'h00F1_BFFC, "R6 ptr read");
        wr(8'h08, 2'd2, 32'h0000_0123, "R6 ptr small");
        chk("R6 ptr small", mtx_ptr_o, 32'h00F1_B120);

        // R7 flags read mask
        wr(8'h00, 2'd2, 32'h0003_FFFF, "R7 flags write");
        chk("R7 flags stored", flags_o, 32'h0003_FFFF);
        rd(8'h00, 2'd2, 32'h0003_C1FF, "R7 flags read");
        chk("R11 no latch change", ctrl_o, 32'h0000_2000);

        // R8, R9, R10 control write rules
        wr(8'h14, 2'd2, 32'hFFFF_FFFF, "R8 ctrl ones");
        chk("R9 host irq pulse", {31'd0, host_irq_o}, 32'd1);
        chk("R8 R10 ctrl ones", ctrl_o, 32'hFFFE_2879);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'd0, host_irq_o}, 32'd0);
        wr(8'h14, 2'd2, 32'h0000_0000, "R8 ctrl zero");
        chk("R9 no pulse", {31'd0, host_irq_o}, 32'd0);
        chk("R8 ctrl zero keeps", ctrl_o, 32'h0000_2040);
        rd(8'h14, 2'd2, 32'h0000_2040, "R8 ctrl read");

        // R11 latch clear through flags
        wr(8'h00, 2'd2, 32'h0000_0200, "R11 clr0");
        chk("R11 clr0", ctrl_o, 32'h0000_2000);
        @(negedge clk); irq_set_i = 6'b100001;
        @(negedge clk); irq_set_i = 6'b000000;
        chk("R10 line set", ctrl_o, 32'h0001_2040);
        wr(8'h00, 2'd2, 32'h0002_0000, "R11 clr5");
        chk("R11 clr5", ctrl_o, 32'h0000_2040);
        wr(8'h00, 2'd2, 32'h0000_3E00, "R11 clr0-4");
        chk("R11 clr all low", ctrl_o, 32'h0000_2000);
        // set and clear in one cycle: set wins
        @(negedge clk);
        exp_q.push_back(32'd0); exp_rd_q.push_back(1'b0); exp_tag_q.push_back("R11 race");
        req_i = 1'b1; we_i = 1'b1; addr_i = 8'h00; size_i = 2'd2; wdata_i = 32'h0002_0000;
        irq_set_i = 6'b100000;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0; irq_set_i = 6'd0;
        chk("R11 set wins", ctrl_o, 32'h0001_2000);
        wr(8'h00, 2'd2, 32'h0002_0000, "R11 clr5 again");
        chk("R11 clr5 again", ctrl_o, 32'h0000_2000);
        // command bit in a byte lane
        wr(8'h17, 2'd0, 32'h0000_0002, "R9 byte cmd");
        chk("R9 byte cmd pulse", {31'd0, host_irq_o}, 32'd1);
        chk("R9 byte cmd not stored", ctrl_o, 32'h0000_2000);

        // R12 accumulator extension
        acc_hi_i = 8'h9C;
        rd(8'h20, 2'd2, 32'hFFFF_FF9C, "R12 negative");
        rd(8'h20, 2'd0, 32'h0000_00FF, "R12 byte0");
        rd(8'h23, 2'd0, 32'h0000_009C, "R12 byte3");
        acc_hi_i = 8'h7F;
        wr(8'h20, 2'd2, 32'h0000_0000, "R12 write");
        rd(8'h20, 2'd2, 32'h0000_007F, "R12 positive after write");

        // R13 unmapped hole
        rd(8'h24, 2'd2, 32'hFFFF_FFFF, "R13 hole 24");
        rd(8'h3C, 2'd2, 32'hFFFF_FFFF, "R13 hole 3c");
        wr(8'h28, 2'd2, 32'hFFFF_FFFF, "R13 hole write");
        chk("R13 pc kept", pc_o, 32'h1111_BEEF);

        // R2 outside the window
        rd(8'h40, 2'd2, 32'd0, "R2 read 40");
        wr(8'h90, 2'd2, 32'h0000_0000, "R2 write 90");
        chk("R2 pc kept", pc_o, 32'h1111_BEEF);

        repeat (3) @(negedge clk);
        chk("R2 all acks seen", exp_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule